// File: doc/BRIEF.md
# Push-Pull Digital PWM Controller

A fixed-frequency pulse-width modulator for switching power-supply control. A free-running counter forms a digital sawtooth that climbs from zero to a programmable terminal count and then restarts. During each sawtooth cycle the counter value is compared with an effective control level. That level is the largest of three values: a built-in minimum dead time, a dead-time word, and the larger of two demand words. A drive output is high only while the counter has reached that level, so a higher demand gives a shorter pulse that ends exactly at the end of the cycle.

A steering flip-flop toggles at every counter wrap. In push-pull mode it sends successive pulses to `q1` and `q2` in turn, so each output runs at half the sawtooth frequency. In single-ended mode steering is held off and both outputs carry the same pulse every cycle. The period, dead-time, demand and mode inputs are all captured only at a wrap, which keeps a cycle in progress intact. Driving `enable` low plays the part of a supply lockout: both drives go low and steering returns to `q1`.

Top module: `pp_pwm_top`

## Requirements
- R1: With a captured terminal count P, one sawtooth cycle lasts P+1 clocks, and `cycleStart` is high for exactly one clock at its start, the clock where the count is zero.
- R2: In each cycle the active drive is high for max(0, P+1-L) clocks, where L is the effective level. The pulse starts on the clock with count L and lasts to the end of the cycle.
- R3: The built-in minimum dead time is floor((P+25)/25) clocks, which is always at least one. It applies with a zero dead-time word, so no drive is ever high in the clock that `cycleStart` is high.
- R4: L is the largest of the minimum dead time, the dead-time word and the larger of `demandA` and `demandB`.
- R5: A dead-time word (or demand) of P+1 or more gives zero on-time in that cycle.
- R6: In push-pull mode (`singleEnded`=0) the first cycle after `enable` rises drives `q1`, and following cycles alternate `q2`, `q1`, and so on.
- R7: In push-pull mode `q1` and `q2` are never high in the same clock.
- R8: In single-ended mode (`singleEnded`=1) `q1` and `q2` are equal in every clock and both pulse in every cycle.
- R9: Period, dead-time, demand and mode inputs are captured only at the wrap, or while `enable` is low. A change made part-way through a cycle first affects the next cycle.
- R10: One clock after `enable` is seen low, `q1`, `q2` and `cycleStart` are low. Steering is reset so the next run starts on `q1`. Active-low reset gives the same idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low means lockout |
| singleEnded | input | 1 | 1 = single-ended, 0 = push-pull |
| period | input | CNT_W | Terminal count P; the cycle is P+1 clocks |
| deadWord | input | CNT_W | Extra dead-time level |
| demandA | input | CNT_W | First demand level |
| demandB | input | CNT_W | Second demand level |
| q1 | output | 1 | Drive output 1 |
| q2 | output | 1 | Drive output 2 |
| cycleStart | output | 1 | One-clock strobe at count zero |

## Verification
Directed runs use all-zero control words, where only the minimum dead time limits the pulse. They also use unequal demands in both orders, to show which demand wins. A dead-time word past the period shows the zero-duty case, and a short period shows the one-clock minimum. A demand changed mid-cycle shows whether capture happens at the wrap or at once. Dropping `enable` after an odd number of cycles shows whether steering really resets. Seeded random periods, words and modes then check the high time, the pulse position, the steering order and the no-overlap rule in every measured cycle. All of these are compared with a bench model of the level formula.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;  // hold counter at zero (lockout)
    logic load;   // capture control words into shadow registers
    logic adv;    // counter running
  } ctlStrobe_t;
endpackage

// File: rtl/pp_pwm_dp.sv
module pp_pwm_dp
  import pp_pwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DEAD_DIV = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] deadWord,
  input  logic [CNT_W-1:0] demandA,
  input  logic [CNT_W-1:0] demandB,
  output logic             atTerm,
  output logic             cntZero,
  output logic             pulseOn
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodR;
  logic [CNT_W-1:0] minDeadR;
  logic [CNT_W-1:0] deadR;
  logic [CNT_W-1:0] demandR;

  logic [EXT_W-1:0] minDeadCalc;
  logic [CNT_W-1:0] demandMax;
  logic [CNT_W-1:0] levelA;
  logic [CNT_W-1:0] level;

  // minimum dead time: ceil((P+1)/DIV), never below one clock
  assign minDeadCalc = ({1'b0, period} + EXT_W'(DEAD_DIV)) / EXT_W'(DEAD_DIV);
  assign demandMax   = (demandA > demandB) ? demandA : demandB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodR  <= '0;
      minDeadR <= CNT_W'(1);
      deadR    <= '0;
      demandR  <= '0;
    end else if (strobe.load) begin
      periodR  <= period;
      minDeadR <= minDeadCalc[CNT_W-1:0];
      deadR    <= deadWord;
      demandR  <= demandMax;
    end
  end

  assign atTerm  = (cnt == periodR);
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clear) begin
      cnt <= '0;
    end else if (strobe.adv) begin
      cnt <= atTerm ? '0 : cnt + CNT_W'(1);
    end
  end

  assign levelA  = (minDeadR > deadR) ? minDeadR : deadR;
  assign level   = (levelA > demandR) ? levelA : demandR;
  assign pulseOn = strobe.adv && (cnt >= level);
endmodule

// File: rtl/pp_pwm_ctl.sv
module pp_pwm_ctl
  import pp_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       singleEnded,
  input  logic       atTerm,
  input  logic       cntZero,
  output ctlStrobe_t strobe,
  output logic       steerSel,
  output logic       singleR,
  output logic       cycleStart
);
  logic runR;
  logic wrap;

  assign wrap = runR && atTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runR <= 1'b0;
    else       runR <= enable;
  end

  always_comb begin
    strobe       = '0;
    strobe.clear = !enable;
    strobe.load  = !enable || wrap;
    strobe.adv   = runR;
  end

  // steering flip-flop and captured mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      steerSel <= 1'b0;
      singleR  <= 1'b0;
    end else if (!enable) begin
      steerSel <= 1'b0;
      singleR  <= singleEnded;
    end else if (wrap) begin
      steerSel <= singleEnded ? 1'b0 : !steerSel;
      singleR  <= singleEnded;
    end
  end

  assign cycleStart = runR && cntZero;
endmodule

// File: rtl/pp_pwm_top.sv
module pp_pwm_top
  import pp_pwm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DEAD_DIV = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             singleEnded,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] deadWord,
  input  logic [CNT_W-1:0] demandA,
  input  logic [CNT_W-1:0] demandB,
  output logic             q1,
  output logic             q2,
  output logic             cycleStart
);
  ctlStrobe_t strobe;
  logic atTerm;
  logic cntZero;
  logic pulseOn;
  logic steerSel;
  logic singleR;

  pp_pwm_ctl u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .singleEnded(singleEnded),
    .atTerm(atTerm), .cntZero(cntZero), .strobe(strobe),
    .steerSel(steerSel), .singleR(singleR), .cycleStart(cycleStart)
  );

  pp_pwm_dp #(.CNT_W(CNT_W), .DEAD_DIV(DEAD_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .period(period),
    .deadWord(deadWord), .demandA(demandA), .demandB(demandB),
    .atTerm(atTerm), .cntZero(cntZero), .pulseOn(pulseOn)
  );

  assign q1 = pulseOn && (singleR || !steerSel);
  assign q2 = pulseOn && (singleR || steerSel);
endmodule

// File: rtl/pp_pwm_checker.sv
module pp_pwm_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic singleR,
  input logic q1,
  input logic q2,
  input logic cycleStart
);
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rstN)
    !singleR |-> !(q1 && q2));

  assert_single_equal_R8: assert property (@(posedge clk) disable iff (!rstN)
    singleR |-> (q1 == q2));

  assert_idle_on_lockout_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!q1 && !q2 && !cycleStart));

  assert_start_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |-> (!q1 && !q2));

  assert_strobe_only_running_R1: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |-> $past(enable));
endmodule

bind pp_pwm_top pp_pwm_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .singleR(singleR),
  .q1(q1), .q2(q2), .cycleStart(cycleStart)
);

// File: tb/tb_pp_pwm_top.sv
module tb_pp_pwm_top;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic singleEnded = 1'b0;
  logic [CW-1:0] period = '0;
  logic [CW-1:0] deadWord = '0;
  logic [CW-1:0] demandA = '0;
  logic [CW-1:0] demandB = '0;
  logic q1, q2, cycleStart;

  int total = 0;
  int bad = 0;
  bit expSel = 1'b0;
  bit finished = 1'b0;

  always #2 clk = !clk;

  pp_pwm_top #(.CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .singleEnded(singleEnded),
    .period(period), .deadWord(deadWord), .demandA(demandA), .demandB(demandB),
    .q1(q1), .q2(q2), .cycleStart(cycleStart)
  );

  function automatic int minDeadOf(int p);
    return (p + 25) / 25;
  endfunction

  function automatic int onTimeOf(int p, int dw, int a, int b);
    int lvl = minDeadOf(p);
    if (dw > lvl) lvl = dw;
    if (a > lvl) lvl = a;
    if (b > lvl) lvl = b;
    return (lvl >= p + 1) ? 0 : (p + 1 - lvl);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // measure one sawtooth cycle; starts just before its first clock
  task automatic measureCycle(input int p, input int expOn, input bit single,
                              input int midIdx, input int midVal, input string tag);
    int n = p + 1;
    int c1 = 0, c2 = 0, ov = 0, extra = 0, first = -1, diff = 0;
    int e1, e2;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk(cycleStart == 1'b1, "R1", int'(cycleStart), 1, {tag, " start strobe"});
        chk(!q1 && !q2, "R3", int'(q1 | q2), 0, {tag, " drive at count zero"});
      end else if (cycleStart) extra++;
      if (q1) c1++;
      if (q2) c2++;
      if (q1 && q2) ov++;
      if (q1 != q2) diff++;
      if ((q1 || q2) && first < 0) first = i;
      if (i == midIdx) demandA = CW'(midVal);
    end
    e1 = (single || !expSel) ? expOn : 0;
    e2 = (single || expSel) ? expOn : 0;
    chk(extra == 0, "R1", extra, 0, {tag, " extra strobes"});
    chk(c1 == e1, "R2", c1, e1, {tag, " q1 high time"});
    chk(c2 == e2, "R6", c2, e2, {tag, " q2 high time"});
    if (expOn > 0)
      chk(first == n - expOn, "R2", first, n - expOn, {tag, " pulse start"});
    if (single) chk(diff == 0, "R8", diff, 0, {tag, " q1/q2 mismatch clocks"});
    else        chk(ov == 0, "R7", ov, 0, {tag, " overlap clocks"});
    if (!singleEnded) expSel = !expSel;
    else              expSel = 1'b0;
  endtask

  task automatic startRun(input int p, input int dw, input int a, input int b, input bit single);
    @(negedge clk);
    enable = 1'b0;
    period = CW'(p); deadWord = CW'(dw); demandA = CW'(a); demandB = CW'(b);
    singleEnded = single;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    expSel = 1'b0;
  endtask

  task automatic runCycles(input int k, input int p, input int dw, input int a, input int b,
                           input bit single, input string tag);
    for (int c = 0; c < k; c++)
      measureCycle(p, onTimeOf(p, dw, a, b), single, -1, 0, tag);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(!q1 && !q2 && !cycleStart, "R10", int'(q1 | q2 | cycleStart), 0, "reset idle");
    rstN = 1'b1;
    @(negedge clk);
    chk(!q1 && !q2 && !cycleStart, "R10", int'(q1 | q2 | cycleStart), 0, "disabled idle");

    // zero control words: minimum dead time only (R3, R6, R7)
    startRun(99, 0, 0, 0, 1'b0);
    runCycles(4, 99, 0, 0, 0, 1'b0, "R3 pp min dead");
    // single-ended, same words (R8)
    startRun(99, 0, 0, 0, 1'b1);
    runCycles(3, 99, 0, 0, 0, 1'b1, "R8 single min dead");
    // larger demand wins, both orders (R4)
    startRun(99, 0, 30, 60, 1'b0);
    runCycles(2, 99, 0, 30, 60, 1'b0, "R4 B larger");
    startRun(99, 0, 70, 20, 1'b1);
    runCycles(2, 99, 0, 70, 20, 1'b1, "R4 A larger");
    // dead-time word above demand
    startRun(63, 40, 10, 5, 1'b0);
    runCycles(2, 63, 40, 10, 5, 1'b0, "R4 dead dominates");
    // dead time past the period: zero duty (R5)
    startRun(49, 60, 0, 0, 1'b1);
    runCycles(2, 49, 60, 0, 0, 1'b1, "R5 zero duty");
    // short period, one-clock minimum (R3)
    startRun(10, 0, 0, 0, 1'b0);
    runCycles(2, 10, 0, 0, 0, 1'b0, "R3 short period");

    // mid-cycle demand change takes effect next cycle (R9)
    startRun(49, 0, 10, 0, 1'b0);
    measureCycle(49, onTimeOf(49, 0, 10, 0), 1'b0, 20, 35, "R9 before change");
    measureCycle(49, onTimeOf(49, 0, 35, 0), 1'b0, -1, 0, "R9 after change");

    // lockout after an odd number of cycles resets steering (R10, R6)
    startRun(29, 0, 0, 0, 1'b0);
    runCycles(3, 29, 0, 0, 0, 1'b0, "R6 before lockout");
    enable = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (q1 || q2 || cycleStart) seen++;
      end
      chk(seen == 0, "R10", seen, 0, "activity during lockout");
    end
    enable = 1'b1;
    expSel = 1'b0;
    runCycles(2, 29, 0, 0, 0, 1'b0, "R10 restart on q1");

    // seeded random trials
    for (int t = 0; t < 24; t++) begin
      int p  = 20 + int'($urandom % 180);
      int dw = ($urandom % 3 == 0) ? int'($urandom % (p + 8)) : 0;
      int a  = int'($urandom % (p + 8));
      int b  = int'($urandom % (p + 8));
      bit s  = 1'($urandom % 2);
      startRun(p, dw, a, b, s);
      runCycles(3, p, dw, a, b, s, "R2 random");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule